// File: doc/BRIEF.md
# Extended Display Data Target with Segment Window

This block is the display-data side of a sink's configuration channel. It sits on a two-wire serial bus as a target, which is the party that answers a controller's commands. It serves identification bytes held in an external synchronous memory of up to 32 KB. Two target addresses are decoded:

- The byte-data address. A write to it sets an 8-bit offset, and a read from it streams bytes out.
- The segment address. A write to it selects which 256-byte window of the memory the byte-data address exposes.

The segment value cannot be read back. It falls back to zero each time the controller ends a command with STOP. A command that writes no segment therefore reads window zero.

The SCL and SDA lines are seen through open-drain inputs. The block can only pull each line low, through `scl_pull` and `sda_pull`. Both inputs are synchronised to the core clock, and START, STOP and the clock edges are recovered from the synchronised samples. Before every byte it sends, the block holds SCL low while it fetches that byte from memory. The fetch is one read strobe followed by one cycle of read latency.

Top module: `edid_ddc_target`

## Requirements
- R1: A write to 8-bit address 0xA0 is acknowledged. The first data byte after it becomes the byte offset and is acknowledged. Further data bytes in that command are acknowledged and ignored.
- R2: A read from 8-bit address 0xA1 is acknowledged and returns memory bytes, MSB first, starting at memory address {segment, offset}. The offset increments after each byte and wraps from 0xFF to 0x00 without changing the segment.
- R3: A write to 8-bit address 0x60 is acknowledged. Its data byte is acknowledged, and its low 7 bits become the segment, which forms `mem_addr[14:8]`.
- R4: The segment is 0 after reset and after every STOP. A command that writes no segment therefore reads window 0.
- R5: A repeated START keeps the segment that was written earlier in the same command.
- R6: Address bytes other than 0xA0, 0xA1 and 0x60 are not acknowledged; this includes 0x61, a read at the segment address. After such a byte the block drives nothing until the next START or STOP.
- R7: When the controller answers a byte with NACK (SDA high), the block releases SDA and issues no further memory read.
- R8: On the SCL falling edge that begins a read byte, the block pulls SCL low for exactly 2 core cycles. One `mem_rd_en` strobe is issued in that window, so there is one stretch per byte read.
- R9: `sda_pull` changes only while SCL is low.
- R10: After reset, `scl_pull`, `sda_pull` and `mem_rd_en` are all 0.
- R11: The byte offset is kept across STOP. A later read without an offset write continues where the previous read ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the serial clock line |
| sda_i | input | 1 | Sensed level of the serial data line |
| scl_pull | output | 1 | 1 pulls the serial clock line low (stretch) |
| sda_pull | output | 1 | 1 pulls the serial data line low |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 15 | Memory byte address {segment, offset} |
| mem_rd_data | input | 8 | Memory read data, valid the cycle after the strobe |

## Verification
Two things meet in the same fetch cycle: the offset increment, and the segment field on the upper address bits. When the offset wraps from 0xFF to 0x00, that one cycle must keep the segment bits unchanged rather than carry into them. The bench provokes this by writing segment 3 and offset 0xFE, then reading four bytes across a repeated START. The scoreboard expects addresses 0x3FE, 0x3FF, 0x300 and 0x301, with the data computed from its own memory pattern. A following command without a segment write must then read window 0 from the offset where the previous read stopped.

// File: rtl/edid_ddc_pkg.sv
`timescale 1ns/1ps
package edid_ddc_pkg;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_OFFSET,
    TGT_READ,
    TGT_SEG
  } ddc_target_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_FETCH,
    ST_LOAD,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } xfer_state_e;

  // Decode a received address byte against the two device addresses.
  function automatic ddc_target_e classify_addr(input logic [7:0] b,
                                                input logic [6:0] byte_dev,
                                                input logic [6:0] seg_dev);
    if (b[7:1] == byte_dev) return b[0] ? TGT_READ : TGT_OFFSET;
    if (b[7:1] == seg_dev && !b[0]) return TGT_SEG;
    return TGT_NONE;
  endfunction

  // Offset advance stays inside the 256-byte window.
  function automatic logic [7:0] next_offset(input logic [7:0] off);
    return off + 8'd1;
  endfunction

endpackage

// File: rtl/ddc_bus_sampler.sv
`timescale 1ns/1ps
module ddc_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_prev, sda_prev;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[0] <= 1'b1;
            sda_pipe[0] <= 1'b1;
          end else begin
            scl_pipe[0] <= scl_i;
            sda_pipe[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
          end else begin
            scl_pipe[g] <= scl_pipe[g-1];
            sda_pipe[g] <= sda_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  assign scl_lvl = scl_pipe[SYNC_STAGES-1];
  assign sda_lvl = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  // SCL high on two successive samples separates START/STOP from clock edges.
  assign ev_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign ev_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
  assign ev_rise  = scl_lvl & ~scl_prev;
  assign ev_fall  = ~scl_lvl & scl_prev;
endmodule

// File: rtl/edid_segment_reg.sv
`timescale 1ns/1ps
module edid_segment_reg #(
  parameter int SEG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [SEG_W-1:0] din,
  output logic [SEG_W-1:0] seg_q
);
  // Clear wins: a command boundary always returns to window zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seg_q <= '0;
    else if (clear) seg_q <= '0;
    else if (load)  seg_q <= din;
  end
endmodule

// File: rtl/ddc_xfer_ctrl.sv
`timescale 1ns/1ps
module ddc_xfer_ctrl
  import edid_ddc_pkg::*;
#(
  parameter int         SEG_W    = 7,
  parameter logic [6:0] BYTE_DEV = 7'h50,
  parameter logic [6:0] SEG_DEV  = 7'h30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_rise,
  input  logic             ev_fall,
  input  logic             sda_lvl,
  input  logic [7:0]       mem_rd_data,
  output logic             sda_pull,
  output logic             scl_pull,
  output logic             mem_rd_en,
  output logic             byte_loaded,
  output logic [7:0]       offset,
  output logic             seg_load,
  output logic [SEG_W-1:0] seg_data
);
  xfer_state_e state;
  ddc_target_e target;
  logic [3:0]  bit_cnt;
  logic [7:0]  rx_sh;
  logic [7:0]  tx_sh;
  logic        ack_q;
  logic        first_wr;
  logic        more_q;
  logic        byte_done;
  ddc_target_e addr_kind;

  assign byte_done = ev_fall && (bit_cnt == 4'd8);
  assign addr_kind = classify_addr(rx_sh, BYTE_DEV, SEG_DEV);

  assign seg_load    = (state == ST_WR_BYTE) && byte_done && (target == TGT_SEG);
  assign seg_data    = rx_sh[SEG_W-1:0];
  assign mem_rd_en   = (state == ST_FETCH);
  assign byte_loaded = (state == ST_LOAD);
  assign scl_pull    = (state == ST_FETCH) || (state == ST_LOAD);
  assign sda_pull    = ack_q || ((state == ST_RD_BYTE) && !tx_sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      target   <= TGT_NONE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= 8'hFF;
      ack_q    <= 1'b0;
      first_wr <= 1'b0;
      more_q   <= 1'b0;
      offset   <= '0;
    end else if (ev_start) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      ack_q   <= 1'b0;
    end else if (ev_stop) begin
      state <= ST_IDLE;
      ack_q <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (ev_rise) begin
            rx_sh   <= {rx_sh[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            if (addr_kind == TGT_NONE) begin
              state <= ST_IGNORE;
            end else begin
              target   <= addr_kind;
              ack_q    <= 1'b1;
              first_wr <= 1'b1;
              state    <= ST_ADDR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev_fall) begin
            ack_q <= 1'b0;
            if (target == TGT_READ) begin
              state <= ST_FETCH;
            end else begin
              state   <= ST_WR_BYTE;
              bit_cnt <= '0;
            end
          end
        end
        ST_WR_BYTE: begin
          if (ev_rise) begin
            rx_sh   <= {rx_sh[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            if (target == TGT_OFFSET && first_wr) offset <= rx_sh;
            first_wr <= 1'b0;
            ack_q    <= 1'b1;
            state    <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (ev_fall) begin
            ack_q   <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_WR_BYTE;
          end
        end
        ST_FETCH: begin
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          tx_sh   <= mem_rd_data;
          offset  <= next_offset(offset);
          bit_cnt <= '0;
          state   <= ST_RD_BYTE;
        end
        ST_RD_BYTE: begin
          if (ev_fall) begin
            tx_sh <= {tx_sh[6:0], 1'b1};
            if (bit_cnt == 4'd7) state <= ST_RD_ACK;
            else bit_cnt <= bit_cnt + 4'd1;
          end
        end
        ST_RD_ACK: begin
          if (ev_rise) begin
            more_q <= ~sda_lvl;
          end else if (ev_fall) begin
            state <= more_q ? ST_FETCH : ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/edid_ddc_target.sv
`timescale 1ns/1ps
module edid_ddc_target #(
  parameter int         MEM_BYTES   = 32768,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] BYTE_DEV    = 7'h50,
  parameter logic [6:0] SEG_DEV     = 7'h30,
  localparam int        SEG_W       = $clog2(MEM_BYTES / 256),
  localparam int        ADDR_W      = SEG_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data
);
  logic             scl_lvl, sda_lvl;
  logic             ev_start, ev_stop, ev_rise, ev_fall;
  logic             seg_load, byte_loaded;
  logic [SEG_W-1:0] seg_data, seg_q;
  logic [7:0]       offset;

  ddc_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  edid_segment_reg #(.SEG_W(SEG_W)) u_segment (
    .clk(clk), .rst_n(rst_n), .clear(ev_stop), .load(seg_load),
    .din(seg_data), .seg_q(seg_q)
  );

  ddc_xfer_ctrl #(.SEG_W(SEG_W), .BYTE_DEV(BYTE_DEV), .SEG_DEV(SEG_DEV)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .sda_lvl(sda_lvl), .mem_rd_data(mem_rd_data),
    .sda_pull(sda_pull), .scl_pull(scl_pull), .mem_rd_en(mem_rd_en),
    .byte_loaded(byte_loaded), .offset(offset),
    .seg_load(seg_load), .seg_data(seg_data)
  );

  assign mem_addr = {seg_q, offset};
endmodule

// File: rtl/edid_ddc_checker.sv
`timescale 1ns/1ps
module edid_ddc_checker #(
  parameter int SEG_W  = 7,
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              ev_rise,
  input logic              ev_fall,
  input logic              scl_pull,
  input logic              sda_pull,
  input logic              mem_rd_en,
  input logic              byte_loaded,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [SEG_W-1:0]  seg_q
);
  AST_BUS_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, ev_stop, ev_rise, ev_fall})); // R9

  AST_SEG_CLEARED_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (seg_q == '0)); // R4

  AST_SEG_KEPT_AT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> $stable(seg_q)); // R5

  AST_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr[ADDR_W-1:8] == seg_q)); // R3

  AST_STRETCH_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> $past(ev_fall)); // R8

  AST_STRETCH_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && $past(scl_pull)) |=> !scl_pull); // R8

  AST_LOAD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_loaded |-> $past(mem_rd_en)); // R8

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull) && !$past(ev_start) && !$past(ev_stop)) |-> !scl_lvl); // R9
endmodule

bind edid_ddc_target edid_ddc_checker #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl),
  .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall),
  .scl_pull(scl_pull), .sda_pull(sda_pull), .mem_rd_en(mem_rd_en),
  .byte_loaded(byte_loaded), .mem_addr(mem_addr), .seg_q(seg_q)
);

// File: tb/edid_ddc_target_test.sv
`timescale 1ns/1ps
module edid_ddc_target_test;
  localparam int Q = 100;              // quarter bit period in ns
  localparam int WATCHDOG_NS = 600000; // 150,000 cycles at 4 ns

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic scl_pull, sda_pull, mem_rd_en;
  logic [14:0] mem_addr;
  logic [7:0]  mem_q = 8'h00;
  wire scl_line = scl_drv & ~scl_pull;
  wire sda_line = sda_drv & ~sda_pull;

  int n_cmp = 0, n_bad = 0;
  int rd_cnt = 0, stretch_rises = 0, stretch_cycles = 0, sda_viol = 0;
  logic prev_pull = 1'b0, prev_sda_pull = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  edid_ddc_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_q)
  );

  function automatic logic [7:0] pat(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_q <= pat(mem_addr);

  // Port monitors, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_en) rd_cnt++;
      if (scl_pull) stretch_cycles++;
      if (scl_pull && !prev_pull) stretch_rises++;
      if (sda_pull != prev_sda_pull && scl_line) sda_viol++;
    end
    prev_pull = scl_pull;
    prev_sda_pull = sda_pull;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pairs each received byte with the expected one.
  initial begin
    forever begin
      @(negedge clk);
      if (obs_q.size() > 0 && exp_q.size() > 0) begin
        automatic logic [7:0] o = obs_q.pop_front();
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(o == e, t, o, e);
      end
    end
  end

  task automatic expect_read(input logic [14:0] a, input string tag);
    exp_q.push_back(pat(a));
    tag_q.push_back(tag);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; scl_drv = 1'b1; #Q;
    wait (scl_line === 1'b1); #Q;
    sda_drv = 1'b0; #Q;
    scl_drv = 1'b0; #Q;
  endtask

  task automatic bus_restart();
    sda_drv = 1'b1; #Q;
    scl_drv = 1'b1; wait (scl_line === 1'b1); #Q;
    sda_drv = 1'b0; #Q;
    scl_drv = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; #Q;
    scl_drv = 1'b1; wait (scl_line === 1'b1); #Q;
    sda_drv = 1'b1; #(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; #Q;
    scl_drv = 1'b1; wait (scl_line === 1'b1); #(2*Q);
    scl_drv = 1'b0; #Q;
  endtask

  task automatic recv_bit(output logic b);
    sda_drv = 1'b1; #Q;
    scl_drv = 1'b1; wait (scl_line === 1'b1); #Q;
    b = sda_line; #Q;
    scl_drv = 1'b0; #Q;
  endtask

  task automatic write_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic read_byte(input bit ack_it, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~ack_it);
    obs_q.push_back(d);
  endtask

  task automatic read_n(input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) read_byte(i != n - 1, d);
  endtask

  initial begin
    #WATCHDOG_NS;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic ak;
    logic [7:0] d;
    #41 rst_n = 1'b1;
    #20;
    check(!scl_pull && !sda_pull && !mem_rd_en, "R10 reset outputs", {scl_pull, sda_pull, mem_rd_en}, 0);

    // Offset write then read, no segment: window 0.
    bus_start();
    write_byte(8'hA0, ak); check(ak, "R1 ack 0xA0", ak, 1);
    write_byte(8'h10, ak); check(ak, "R1 ack offset byte", ak, 1);
    write_byte(8'h77, ak); check(ak, "R1 extra byte acked", ak, 1);
    bus_restart();
    write_byte(8'hA1, ak); check(ak, "R2 ack 0xA1", ak, 1);
    for (int i = 0; i < 4; i++) expect_read(15'h0010 + 15'(i), "R2 R4 window0 read");
    read_n(4);
    bus_stop();
    check(stretch_rises == 4, "R8 stretch count", stretch_rises, 4);
    check(stretch_cycles == 8, "R8 stretch length", stretch_cycles, 8);

    // Segment 3, offset 0xFE, wrap inside the window.
    bus_start();
    write_byte(8'h60, ak); check(ak, "R3 ack 0x60", ak, 1);
    write_byte(8'h03, ak); check(ak, "R3 ack segment byte", ak, 1);
    bus_restart();
    write_byte(8'hA0, ak); check(ak, "R5 ack after restart", ak, 1);
    write_byte(8'hFE, ak);
    bus_restart();
    write_byte(8'hA1, ak);
    expect_read(15'h03FE, "R5 segment kept");
    expect_read(15'h03FF, "R2 before wrap");
    expect_read(15'h0300, "R2 wrap keeps segment");
    expect_read(15'h0301, "R2 after wrap");
    read_n(4);
    bus_stop();
    check(rd_cnt == 8, "R7 no fetch after NACK", rd_cnt, 8);

    // After STOP: segment back to 0, offset kept at 0x02.
    bus_start();
    write_byte(8'hA1, ak); check(ak, "R11 ack read", ak, 1);
    expect_read(15'h0002, "R4 R11 offset kept seg cleared");
    expect_read(15'h0003, "R11 continue");
    read_n(2);
    bus_stop();

    // Read at segment address is refused.
    bus_start();
    write_byte(8'h61, ak); check(!ak, "R6 0x61 not acked", ak, 0);
    read_byte(1'b0, d);
    void'(obs_q.pop_back());
    check(d == 8'hFF, "R6 bus left released", d, 8'hFF);
    bus_stop();

    bus_start();
    write_byte(8'h42, ak); check(!ak, "R6 foreign address", ak, 0);
    bus_stop();

    // Segment byte with bit 7 set: only low 7 bits used.
    bus_start();
    write_byte(8'h60, ak);
    write_byte(8'h85, ak); check(ak, "R3 ack 0x85", ak, 1);
    bus_restart();
    write_byte(8'hA0, ak);
    write_byte(8'h00, ak);
    bus_restart();
    write_byte(8'hA1, ak);
    expect_read(15'h0500, "R3 segment low bits");
    read_n(1);
    bus_stop();

    repeat (20) @(negedge clk);
    check(rd_cnt == 11, "R7 total fetches", rd_cnt, 11);
    check(stretch_rises == 11, "R8 one stretch per byte", stretch_rises, 11);
    check(sda_viol == 0, "R9 SDA moves only with SCL low", sda_viol, 0);
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule